// File: doc/BRIEF.md
# Half-Duplex Byte SPI Master with Register Access

This block is a serial-peripheral-interface master that software drives through four 32-bit registers. A byte goes out when software places it in the data register and then writes the control register with the transmit command. A byte comes in when software writes the receive command and, after the busy flag drops, reads the captured value back from the same data register. Each command moves exactly eight bits in one direction only. During a transmit, whatever arrives on the input line is thrown away. During a receive, the output line stays at its idle level of 0.

The configuration register holds four settings. The first is whether the most or the least significant bit is shifted first. The second is the level of the serial clock at rest. The third and fourth pick, independently, which clock edge launches output data and which edge samples input data. The same register holds a three-bit prescaler that divides the system clock by a power of two, and one of its codes stops the serial clock. The control register also holds a chip-select bit, which is active low and drives the pin directly, and a bit that releases the data output to high impedance.

The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready pairing and never applies back-pressure: every write is taken in the cycle it is presented. Software must poll the busy flag before issuing the next command.

Top module: `spi_hd_master`

## Requirements
- R1: Status register (offset 0x00) bit 0 is the busy flag. It becomes 1 in the cycle after an accepted command and stays 1 for exactly 16·2^k system cycles, where k is the prescale code.
- R2: Config bits [2:0] hold the prescale code k. For k from 0 to 6, each serial-clock half period lasts 2^k system cycles, which divides the system clock by 2^(k+1).
- R3: Whenever the block is not busy, the serial clock sits at config bit 6. Each transfer makes 16 toggles, starting from that level and ending back at it.
- R4: Config bit 8 set means most-significant-bit first, for both sent and received bytes. Clear means least-significant-bit first.
- R5: Config bit 4 set makes the falling serial-clock edge launch output bits, and clear makes the rising edge launch them. When the launch edge is the first edge of the transfer, bit 0 of the sequence is shown from the start and the first launch edge does not advance it. Otherwise each launch edge advances to the next bit.
- R6: Config bit 5 set makes the falling edge sample the input, and clear makes the rising edge sample it. A receive takes 8 samples and writes the byte into data register (offset 0x20) bits [7:0] at the end of the transfer.
- R7: Control register (offset 0x14) bit 0 drives the chip-select pin directly. Writing 0 asserts the select (pin low) and writing 1 releases it. This bit is taken even while busy.
- R8: Control bit 3 set turns the data output enable off (high impedance). Clear turns it on.
- R9: Writing control bit 2 starts a transmit of data bits [7:0], and writing control bit 1 starts a receive. Transmit wins if both are set. A command, a data write or a config write that arrives while busy is ignored. Command bits read back as 0.
- R10: A command written while the prescale code is 7 is ignored, and busy stays 0.
- R11: The data output is 0 whenever the block is not busy and throughout a receive. A transmit leaves the data register unchanged.
- R12: After reset, every register reads 0. This means chip select is asserted, the output is enabled, and the serial clock is 0. Config reads back in bits 8, 6, 5, 4 and [2:0], control in bits 3 and 0, data in bits [7:0], and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| reg_addr | input | 8 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi (1 = driven) |
| miso | input | 1 | Serial data in |

## Verification
Several properties are checked on every cycle. The serial clock rests at its polarity and the output rests at 0 whenever the block is idle. Busy never rises without a command write in the cycle before. The configuration cannot change during a transfer. Each busy window lasts exactly sixteen half periods of the active prescale. The other behaviours can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock while sweeping all sixteen combinations of bit order, polarity and edge choice. These are the exact bit launched after each edge, the bits assembled from the input line, ignored commands, the stopped-clock code, and chip-select and tri-state control.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;
  localparam int PRE_W  = 3;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h20;

  // config field positions
  localparam int CFG_MSB_BIT  = 8;
  localparam int CFG_CPOL_BIT = 6;
  localparam int CFG_RXF_BIT  = 5;
  localparam int CFG_TXF_BIT  = 4;

  // control field positions
  localparam int CTL_HIZ_BIT  = 3;
  localparam int CTL_TX_BIT   = 2;
  localparam int CTL_RX_BIT   = 1;
  localparam int CTL_CS_BIT   = 0;

  typedef struct packed {
    logic             msb_first;
    logic             cpol;
    logic             rx_fall;
    logic             tx_fall;
    logic [PRE_W-1:0] presc;
  } cfg_t;
endpackage

// File: rtl/spi_hd_regs.sv
module spi_hd_regs
  import spi_hd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output cfg_t              cfg_q,
  output logic              cs_n_q,
  output logic              hiz_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              start,
  output logic              start_tx,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [PRE_W-1:0] PRE_OFF = '1;

  logic wr_cfg, wr_ctl, wr_data, cmd_req;

  assign wr_cfg   = reg_wr && (reg_addr == OFS_CFG);
  assign wr_ctl   = reg_wr && (reg_addr == OFS_CTL);
  assign wr_data  = reg_wr && (reg_addr == OFS_DATA);
  assign cmd_req  = reg_wdata[CTL_TX_BIT] || reg_wdata[CTL_RX_BIT];
  assign start    = wr_ctl && cmd_req && !busy && (cfg_q.presc != PRE_OFF);
  assign start_tx = reg_wdata[CTL_TX_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cs_n_q <= 1'b0;
      hiz_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_cfg && !busy) begin
        cfg_q.msb_first <= reg_wdata[CFG_MSB_BIT];
        cfg_q.cpol      <= reg_wdata[CFG_CPOL_BIT];
        cfg_q.rx_fall   <= reg_wdata[CFG_RXF_BIT];
        cfg_q.tx_fall   <= reg_wdata[CFG_TXF_BIT];
        cfg_q.presc     <= reg_wdata[PRE_W-1:0];
      end
      if (wr_ctl) begin
        cs_n_q <= reg_wdata[CTL_CS_BIT];
        hiz_q  <= reg_wdata[CTL_HIZ_BIT];
      end
      if (rx_done)
        data_q <= rx_byte;
      else if (wr_data && !busy)
        data_q <= reg_wdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STATUS: reg_rdata[0] = busy;
      OFS_CFG: begin
        reg_rdata[CFG_MSB_BIT]  = cfg_q.msb_first;
        reg_rdata[CFG_CPOL_BIT] = cfg_q.cpol;
        reg_rdata[CFG_RXF_BIT]  = cfg_q.rx_fall;
        reg_rdata[CFG_TXF_BIT]  = cfg_q.tx_fall;
        reg_rdata[PRE_W-1:0]    = cfg_q.presc;
      end
      OFS_CTL: begin
        reg_rdata[CTL_HIZ_BIT] = hiz_q;
        reg_rdata[CTL_CS_BIT]  = cs_n_q;
      end
      OFS_DATA: reg_rdata[BYTE_W-1:0] = data_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_hd_clkdiv.sv
module spi_hd_clkdiv #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int MAX_SH = (1 << PRE_W) - 2;
  localparam int CNT_W  = MAX_SH + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(1) << code) - CNT_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || tick)
      cnt <= '0;
    else
      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_hd_shifter.sv
module spi_hd_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_tx,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              msb_first,
  input  logic              cpol,
  input  logic              rx_fall,
  input  logic              tx_fall,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk_q,
  output logic              mosi_bit,
  output logic              tx_active,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EC_W  = $clog2(EDGES + 1);

  logic              is_tx;
  logic [EC_W-1:0]   edge_cnt;
  logic [BYTE_W-1:0] tx_sh, rx_sh, rx_next;
  logic              rising, falling, launch, capture, lead_launch, skip, last;

  assign rising      = tick && !sclk_q;
  assign falling     = tick && sclk_q;
  assign launch      = tx_fall ? falling : rising;
  assign capture     = rx_fall ? falling : rising;
  assign lead_launch = (tx_fall == cpol);
  assign skip        = lead_launch && (edge_cnt == '0);
  assign last        = busy && tick && (edge_cnt == EC_W'(EDGES - 1));

  assign rx_next   = msb_first ? {rx_sh[BYTE_W-2:0], miso} : {miso, rx_sh[BYTE_W-1:1]};
  assign rx_byte   = capture ? rx_next : rx_sh;
  assign rx_done   = last && !is_tx;
  assign mosi_bit  = msb_first ? tx_sh[BYTE_W-1] : tx_sh[0];
  assign tx_active = busy && is_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_tx    <= 1'b0;
      sclk_q   <= 1'b0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      is_tx    <= start_tx;
      sclk_q   <= cpol;
      edge_cnt <= '0;
      tx_sh    <= tx_byte;
      rx_sh    <= '0;
    end else if (busy && tick) begin
      sclk_q   <= ~sclk_q;
      edge_cnt <= edge_cnt + EC_W'(1);
      if (launch && !skip)
        tx_sh <= msb_first ? {tx_sh[BYTE_W-2:0], 1'b0} : {1'b0, tx_sh[BYTE_W-1:1]};
      if (capture && !is_tx)
        rx_sh <= rx_next;
      if (last)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_hd_master.sv
module spi_hd_master
  import spi_hd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso
);
  cfg_t              cfg_q;
  logic              busy, start, start_tx, rx_done, tick;
  logic              hiz_q, sclk_q, mosi_bit, tx_active;
  logic [BYTE_W-1:0] data_q, rx_byte;

  spi_hd_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .rx_done(rx_done), .rx_byte(rx_byte),
    .cfg_q(cfg_q), .cs_n_q(cs_n), .hiz_q(hiz_q), .data_q(data_q),
    .start(start), .start_tx(start_tx), .reg_rdata(reg_rdata)
  );

  spi_hd_clkdiv #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(cfg_q.presc), .tick(tick)
  );

  spi_hd_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tx(start_tx),
    .tx_byte(data_q), .msb_first(cfg_q.msb_first), .cpol(cfg_q.cpol),
    .rx_fall(cfg_q.rx_fall), .tx_fall(cfg_q.tx_fall), .tick(tick),
    .miso(miso), .busy(busy), .sclk_q(sclk_q), .mosi_bit(mosi_bit),
    .tx_active(tx_active), .rx_done(rx_done), .rx_byte(rx_byte)
  );

  assign sclk    = busy ? sclk_q : cfg_q.cpol;
  assign mosi    = tx_active && mosi_bit;
  assign mosi_oe = !hiz_q;
endmodule

// File: rtl/spi_hd_master_chk.sv
module spi_hd_master_chk
  import spi_hd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              sclk,
  input logic              mosi,
  input logic              busy,
  input cfg_t              cfg_q
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int LEN_W = $clog2(EDGES << ((1 << PRE_W) - 2)) + 2;

  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= '0;
    else if (busy) run_len <= run_len + LEN_W'(1);
    else           run_len <= '0;
  end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_q.cpol));

  // R11
  mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  // R1
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && (reg_addr == OFS_CTL) &&
                          (reg_wdata[CTL_TX_BIT] || reg_wdata[CTL_RX_BIT])));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (LEN_W'(EDGES) << cfg_q.presc)));
endmodule

bind spi_hd_master spi_hd_master_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sclk(sclk), .mosi(mosi), .busy(busy), .cfg_q(cfg_q)
);

// File: tb/spi_hd_master_tb.sv
`timescale 1ns/1ps
module spi_hd_master_tb;
  import spi_hd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = OFS_STATUS;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, cs_n, mosi, mosi_oe;
  logic        miso = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_hd_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
  );

  // pseudo-random slave data
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[15];
  end

  // behavioural reference model
  bit       m_busy = 0, m_tx = 0, m_msb = 0, m_cpol = 0, m_rxf = 0, m_txf = 0;
  bit       m_cs = 0, m_hiz = 0;
  int       m_pre = 0, m_el = 0, m_n = 0, m_rxc = 0;
  bit [7:0] m_data = 0, m_txb = 0, m_rxb = 0;

  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      m_busy = 0; m_tx = 0; m_msb = 0; m_cpol = 0; m_rxf = 0; m_txf = 0;
      m_cs = 0; m_hiz = 0; m_pre = 0; m_data = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        m_el++;
        if (m_el % (1 << m_pre) == 0) begin
          m_n = m_el / (1 << m_pre);
          if (!m_tx && (((m_n % 2) == 1) == (m_rxf == m_cpol))) begin
            if (m_msb) m_rxb[7 - m_rxc] = miso;
            else       m_rxb[m_rxc] = miso;
            m_rxc++;
          end
          if (m_n == 16) begin
            m_busy = 0;
            if (!m_tx) m_data = m_rxb;
          end
        end
      end
      if (reg_wr) begin
        if (reg_addr == OFS_CFG && !was_busy) begin
          m_msb = reg_wdata[8]; m_cpol = reg_wdata[6];
          m_rxf = reg_wdata[5]; m_txf = reg_wdata[4];
          m_pre = int'(reg_wdata[2:0]);
        end
        if (reg_addr == OFS_CTL) begin
          m_cs = reg_wdata[0]; m_hiz = reg_wdata[3];
          if (!was_busy && (reg_wdata[2] || reg_wdata[1]) && m_pre != 7) begin
            m_busy = 1; m_tx = reg_wdata[2]; m_el = 0; m_n = 0;
            m_rxc = 0; m_rxb = 0; m_txb = m_data;
          end
        end
        if (reg_addr == OFS_DATA && !was_busy) m_data = reg_wdata[7:0];
      end
    end
  end

  function automatic logic exp_sclk();
    return m_busy ? logic'(m_cpol ^ (m_n % 2)) : logic'(m_cpol);
  endfunction

  function automatic logic exp_mosi();
    int idx;
    if (!m_busy || !m_tx) return 1'b0;
    if (m_txf == m_cpol) idx = (m_n == 0) ? 0 : (m_n - 1) / 2;
    else                 idx = m_n / 2;
    if (idx > 7) return 1'b0;
    return m_msb ? m_txb[7 - idx] : m_txb[idx];
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (reg_addr)
      OFS_STATUS: return {31'b0, m_busy};
      OFS_CFG:    return {23'b0, m_msb, 1'b0, m_cpol, m_rxf, m_txf, 1'b0, 3'(m_pre)};
      OFS_CTL:    return {28'b0, m_hiz, 2'b0, m_cs};
      OFS_DATA:   return {24'b0, m_data};
      default:    return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    chk("R2 R3 sclk", {31'b0, sclk}, {31'b0, exp_sclk()});
    chk("R4 R5 R11 mosi", {31'b0, mosi}, {31'b0, exp_mosi()});
    chk("R7 cs_n", {31'b0, cs_n}, {31'b0, m_cs});
    chk("R8 mosi_oe", {31'b0, mosi_oe}, {31'b0, !m_hiz});
    chk("R1 R6 R9 R10 R12 rdata", reg_rdata, exp_rdata());
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = OFS_STATUS; reg_wdata = '0;
  endtask

  task automatic look(input logic [7:0] a);
    @(posedge clk); #1;
    reg_addr = a;
    @(posedge clk); #1;
    reg_addr = OFS_STATUS;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] cfg_word(bit msb, bit cpol, bit rxf, bit txf, int pre);
    return {23'b0, msb, 1'b0, cpol, rxf, txf, 1'b0, 3'(pre)};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    // R12: reset state and register layout
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    look(OFS_CFG); look(OFS_CTL); look(OFS_DATA); look(8'h04);

    // R4 R5 R6 R11: a transmit then a receive in every edge and order mode
    for (int m = 0; m < 16; m++) begin
      wr(OFS_CFG, cfg_word(m[3], m[2], m[1], m[0], m % 3));
      wr(OFS_DATA, 32'(8'h3C ^ (m * 17)));
      wr(OFS_CTL, 32'h4);                  // transmit, chip select asserted
      wait_idle();
      look(OFS_DATA);                      // R11: data unchanged by transmit
      wr(OFS_CTL, 32'h2);                  // receive
      wait_idle();
      look(OFS_DATA);                      // R6: captured byte
    end

    // R9: commands, data and config writes while busy are ignored; R7 taken
    wr(OFS_CFG, cfg_word(1, 1, 0, 1, 2));
    wr(OFS_DATA, 32'h96);
    wr(OFS_CTL, 32'h4);
    wr(OFS_DATA, 32'hFF);
    wr(OFS_CFG, cfg_word(0, 0, 1, 0, 0));
    wr(OFS_CTL, 32'h3);                    // R7: release select mid-transfer
    look(OFS_CFG);
    wait_idle();
    look(OFS_DATA);

    // R9: both command bits at once runs a transmit
    wr(OFS_CTL, 32'h6);
    wait_idle();

    // R10: stopped-clock code ignores commands
    wr(OFS_CFG, cfg_word(1, 0, 0, 0, 7));
    wr(OFS_CTL, 32'h4);
    repeat (6) @(posedge clk);
    wr(OFS_CTL, 32'h2);
    repeat (6) @(posedge clk);

    // R8: output released, then restored; R2 slowest prescale
    wr(OFS_CTL, 32'h8);
    wr(OFS_CFG, cfg_word(0, 1, 1, 0, 6));
    wr(OFS_CTL, 32'hC);
    wait_idle();
    wr(OFS_CTL, 32'h2);
    wait_idle();
    look(OFS_DATA);
    wr(OFS_CTL, 32'h1);
    repeat (4) @(posedge clk);

    summary();
    $finish;
  end
endmodule